// File: doc/BRIEF.md
# MAC Address Learning Table

This block keeps the station table of a small Ethernet switch. It maps each learned unicast MAC address to the switch port the address was last seen on. There are two request streams. The learn stream carries a frame's source address and ingress port, together with two qualifiers given at the end of the frame: the frame arrived error-free, and the frame is a flow-control PAUSE frame. The lookup stream carries a destination address. One cycle after it is accepted, the block returns a hit flag and the stored port. A miss tells the forwarding logic to flood the frame.

Each slot holds a valid bit, an address tag, a port number and a small saturating age count. The slot index comes from the address in one of two ways, chosen by a configuration input:
- the low index bits of the address taken directly, or
- an XOR fold of all 48 address bits.

The tag is always the address bits above the index. This lets a stored entry be compared exactly in either mode.

A background sweeper walks the whole table once for every age tick, while aging is enabled. On each visit it advances the age of every valid slot, and it invalidates any slot that has reached the programmed limit. The tick is an input, so the real aging period (minutes) can be scaled down to a handful of cycles for test.

The lookup stream has a ready that is always high. The learn stream's ready is low in any cycle that holds a lookup request, so a learn request must hold its payload stable until the cycle in which ready is high. Results carry no back-pressure: the result pins are valid for exactly one cycle.

Top module: `mac_learn_table`

## Requirements
- R1: After reset every slot is invalid. Every lookup misses, and `res_valid` is low until a lookup is accepted.
- R2: A lookup accepted at a clock edge is answered at the next edge with `res_valid` high for one cycle. On a hit, `res_port` is the stored port. On a miss, `res_port` is 0.
- R3: A lookup whose address has bit 40 set (group address; bit 40 is bit 0 of the first octet when the address is held as `mac[47:0]` with the first octet in bits 47:40) always reports a miss.
- R4: A learn request changes no slot if any of these holds: `lrn_good` is 0, `lrn_pause` is 1, or the source address has bit 40 set.
- R5: A committed learn writes the slot with valid set, the new tag, the ingress port and age 0. This applies both to a new address and to a relearned address, so relearning refreshes the age and moves the address to the new port.
- R6: With `cfg_hash`=0 the slot index is `mac[IDX_W-1:0]`. With `cfg_hash`=1, index bit b is the XOR of every address bit i with i mod IDX_W = b. The tag is `mac[47:IDX_W]`. Two addresses that share an index evict each other, and the last one learned wins.
- R7: `lkp_ready` is always 1. `lrn_ready` is low whenever `lkp_valid` is high. A learn accepted at an edge is visible to a lookup accepted at the following edge.
- R8: While `cfg_age_en` is 1, an `age_tick` pulse causes one full sweep. During the sweep, each valid slot whose age is below `cfg_age_limit` has its age advanced by 1, and each valid slot whose age has reached `cfg_age_limit` is invalidated. An entry left untouched therefore survives `cfg_age_limit` sweeps and is gone after the next one.
- R9: While `cfg_age_en` is 0, ticks are ignored and no sweep starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_hash | input | 1 | 1 selects the XOR-fold index, 0 selects direct low bits |
| cfg_age_en | input | 1 | Enables aging sweeps |
| cfg_age_limit | input | AGE_W | Age at which a visited slot is invalidated |
| age_tick | input | 1 | One-cycle pulse that requests a sweep |
| lrn_valid | input | 1 | Learn request valid |
| lrn_ready | output | 1 | Learn request accepted this cycle |
| lrn_mac | input | 48 | Source address to learn |
| lrn_port | input | PORT_W | Ingress port of the frame |
| lrn_good | input | 1 | Frame finished without error |
| lrn_pause | input | 1 | Frame is a PAUSE frame |
| lkp_valid | input | 1 | Lookup request valid |
| lkp_ready | output | 1 | Lookup request accepted (always 1) |
| lkp_mac | input | 48 | Destination address to look up |
| res_valid | output | 1 | Lookup result valid, one cycle after acceptance |
| res_hit | output | 1 | Lookup matched a valid slot |
| res_port | output | PORT_W | Port of the matching slot, 0 on a miss |

## Verification
The lookup result is registered once, so the bench drives a request half a cycle before an edge and samples the result 1 ns after that same edge. A learn handshake writes the slot at its own edge, so the bench learns and then looks up at the next edge, with no idle gap needed. A sweep starts one edge after the tick is registered and spends one cycle per slot when it is not pre-empted. The bench waits the slot count plus a margin before it compares the table against its arithmetic model. The arbitration case is timed edge by edge: `lrn_ready` is checked low in the shared cycle, the lookup result shows the old table, and a later lookup shows the learned entry.

// File: rtl/mlt_pkg.sv
package mlt_pkg;
  localparam int MAC_W     = 48;
  localparam int GROUP_BIT = 40;

  typedef enum logic [1:0] {
    GNT_NONE = 2'd0,
    GNT_LKP  = 2'd1,
    GNT_LRN  = 2'd2,
    GNT_SWP  = 2'd3
  } gnt_e;
endpackage

// File: rtl/mlt_index.sv
module mlt_index #(
  parameter int IDX_W = 11
) (
  input  logic [mlt_pkg::MAC_W-1:0]       mac,
  input  logic                            hash_sel,
  output logic [IDX_W-1:0]                idx,
  output logic [mlt_pkg::MAC_W-IDX_W-1:0] tag
);
  localparam int MAC_W = mlt_pkg::MAC_W;

  logic [IDX_W-1:0] fold;

  // Each index bit collects every address bit that lands on it modulo IDX_W.
  for (genvar b = 0; b < IDX_W; b++) begin : g_fold
    always_comb begin
      fold[b] = 1'b0;
      for (int k = b; k < MAC_W; k += IDX_W) fold[b] = fold[b] ^ mac[k];
    end
  end

  assign idx = hash_sel ? fold : mac[IDX_W-1:0];
  assign tag = mac[MAC_W-1:IDX_W];
endmodule

// File: rtl/mlt_store.sv
module mlt_store #(
  parameter int IDX_W  = 11,
  parameter int TAG_W  = 37,
  parameter int PORT_W = 4,
  parameter int AGE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [PORT_W-1:0] rd_port,
  output logic [AGE_W-1:0]  rd_age,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [PORT_W-1:0] wr_port,
  input  logic [AGE_W-1:0]  wr_age
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [PORT_W-1:0] port_q [DEPTH];
  logic [AGE_W-1:0]  age_q  [DEPTH];

  // Only the valid bits need reset; payload is gated by them.
  always_ff @(posedge clk) begin
    if (!rst_n)     valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      port_q[wr_idx] <= wr_port;
      age_q[wr_idx]  <= wr_age;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_port  = port_q[rd_idx];
  assign rd_age   = age_q[rd_idx];
endmodule

// File: rtl/mlt_sweeper.sv
module mlt_sweeper #(
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             age_en,
  input  logic             tick,
  input  logic             step,
  output logic             active,
  output logic [IDX_W-1:0] idx
);
  logic             pending_q, active_q;
  logic [IDX_W-1:0] idx_q;
  logic             start;

  assign start = !active_q && pending_q && age_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      active_q  <= 1'b0;
      idx_q     <= '0;
    end else begin
      pending_q <= age_en && ((pending_q && !start) || tick);
      if (start) begin
        active_q <= 1'b1;
        idx_q    <= '0;
      end else if (active_q && step) begin
        if (&idx_q) active_q <= 1'b0;
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign active = active_q;
  assign idx    = idx_q;
endmodule

// File: rtl/mac_learn_table.sv
module mac_learn_table #(
  parameter int IDX_W  = 11,
  parameter int PORT_W = 4,
  parameter int AGE_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_hash,
  input  logic                      cfg_age_en,
  input  logic [AGE_W-1:0]          cfg_age_limit,
  input  logic                      age_tick,
  input  logic                      lrn_valid,
  output logic                      lrn_ready,
  input  logic [mlt_pkg::MAC_W-1:0] lrn_mac,
  input  logic [PORT_W-1:0]         lrn_port,
  input  logic                      lrn_good,
  input  logic                      lrn_pause,
  input  logic                      lkp_valid,
  output logic                      lkp_ready,
  input  logic [mlt_pkg::MAC_W-1:0] lkp_mac,
  output logic                      res_valid,
  output logic                      res_hit,
  output logic [PORT_W-1:0]         res_port
);
  import mlt_pkg::*;
  localparam int TAG_W = MAC_W - IDX_W;

  logic [IDX_W-1:0]  lkp_idx, lrn_idx, swp_idx, rd_idx, wr_idx;
  logic [TAG_W-1:0]  lkp_tag, lrn_tag, rd_tag, wr_tag;
  logic              rd_valid, wr_en, wr_valid, swp_active, hit_c;
  logic [PORT_W-1:0] rd_port, wr_port;
  logic [AGE_W-1:0]  rd_age, wr_age;
  gnt_e              gnt;

  mlt_index #(.IDX_W(IDX_W)) u_lkp_idx (
    .mac(lkp_mac), .hash_sel(cfg_hash), .idx(lkp_idx), .tag(lkp_tag));
  mlt_index #(.IDX_W(IDX_W)) u_lrn_idx (
    .mac(lrn_mac), .hash_sel(cfg_hash), .idx(lrn_idx), .tag(lrn_tag));

  // One table access per cycle: lookup, then learn, then sweep.
  always_comb begin
    if (lkp_valid)       gnt = GNT_LKP;
    else if (lrn_valid)  gnt = GNT_LRN;
    else if (swp_active) gnt = GNT_SWP;
    else                 gnt = GNT_NONE;
  end

  assign lkp_ready = 1'b1;
  assign lrn_ready = !lkp_valid;
  assign rd_idx    = (gnt == GNT_SWP) ? swp_idx : lkp_idx;

  mlt_sweeper #(.IDX_W(IDX_W)) u_swp (
    .clk(clk), .rst_n(rst_n), .age_en(cfg_age_en), .tick(age_tick),
    .step(gnt == GNT_SWP), .active(swp_active), .idx(swp_idx));

  always_comb begin
    wr_en    = 1'b0;
    wr_idx   = lrn_idx;
    wr_valid = 1'b1;
    wr_tag   = lrn_tag;
    wr_port  = lrn_port;
    wr_age   = '0;
    case (gnt)
      GNT_LRN: wr_en = lrn_good && !lrn_pause && !lrn_mac[GROUP_BIT];
      GNT_SWP: begin
        wr_en   = rd_valid;
        wr_idx  = swp_idx;
        wr_tag  = rd_tag;
        wr_port = rd_port;
        if (rd_age >= cfg_age_limit) begin
          wr_valid = 1'b0;
          wr_age   = rd_age;
        end else begin
          wr_age = (&rd_age) ? rd_age : rd_age + 1'b1;
        end
      end
      default: wr_en = 1'b0;
    endcase
  end

  mlt_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PORT_W(PORT_W), .AGE_W(AGE_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_port(rd_port), .rd_age(rd_age),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_tag(wr_tag),
    .wr_port(wr_port), .wr_age(wr_age));

  assign hit_c = lkp_valid && !lkp_mac[GROUP_BIT] && rd_valid && (rd_tag == lkp_tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_port  <= '0;
    end else begin
      res_valid <= lkp_valid;
      res_hit   <= hit_c;
      res_port  <= hit_c ? rd_port : '0;
    end
  end
endmodule

// File: rtl/mlt_checker.sv
module mlt_checker #(
  parameter int PORT_W = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      lkp_valid,
  input logic                      lkp_ready,
  input logic [mlt_pkg::MAC_W-1:0] lkp_mac,
  input logic                      lrn_ready,
  input logic                      res_valid,
  input logic                      res_hit,
  input logic [PORT_W-1:0]         res_port,
  input logic                      cfg_age_en,
  input logic                      swp_active
);
  assert_res_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid |=> res_valid);
  assert_res_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_valid |=> !res_valid);
  assert_hit_in_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> res_valid);
  assert_miss_port_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !res_hit |-> (res_port == '0));
  assert_group_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && lkp_mac[mlt_pkg::GROUP_BIT]) |=> !res_hit);
  assert_lookup_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid |-> (!lrn_ready && lkp_ready));
  assert_no_sweep_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_age_en && !swp_active) |=> !swp_active);
endmodule

bind mac_learn_table mlt_checker #(.PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .lkp_ready(lkp_ready),
  .lkp_mac(lkp_mac), .lrn_ready(lrn_ready), .res_valid(res_valid),
  .res_hit(res_hit), .res_port(res_port), .cfg_age_en(cfg_age_en),
  .swp_active(swp_active));

// File: tb/sim_mac_learn_table.sv
`timescale 1ns/1ps
module sim_mac_learn_table;
  localparam int IW = 4, PW = 4, AW = 3, DEPTH = 1 << IW;

  logic clk = 0, rst_n = 0;
  logic cfg_hash = 0, cfg_age_en = 0, age_tick = 0;
  logic [AW-1:0] cfg_age_limit = 3'd2;
  logic lrn_valid = 0, lrn_good = 0, lrn_pause = 0, lkp_valid = 0;
  logic [47:0] lrn_mac = '0, lkp_mac = '0;
  logic [PW-1:0] lrn_port = '0;
  logic lrn_ready, lkp_ready, res_valid, res_hit;
  logic [PW-1:0] res_port;

  int checks = 0, errors = 0;
  bit done = 0;

  bit          m_v   [DEPTH];
  logic [47:0] m_mac [DEPTH];
  logic [PW-1:0] m_port [DEPTH];
  int          m_age [DEPTH];

  always #2.5 clk = ~clk;

  mac_learn_table #(.IDX_W(IW), .PORT_W(PW), .AGE_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_hash(cfg_hash), .cfg_age_en(cfg_age_en),
    .cfg_age_limit(cfg_age_limit), .age_tick(age_tick),
    .lrn_valid(lrn_valid), .lrn_ready(lrn_ready), .lrn_mac(lrn_mac), .lrn_port(lrn_port),
    .lrn_good(lrn_good), .lrn_pause(lrn_pause),
    .lkp_valid(lkp_valid), .lkp_ready(lkp_ready), .lkp_mac(lkp_mac),
    .res_valid(res_valid), .res_hit(res_hit), .res_port(res_port));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int slot(logic [47:0] m);
    logic [47:0] h = '0;
    if (!cfg_hash) return int'(m % DEPTH);
    for (int c = 0; c < 48; c += IW) h = h ^ ((m >> c) % DEPTH);
    return int'(h);
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin m_v[i] = 0; m_age[i] = 0; end
    rst_n = 1;
  endtask

  task automatic learn(logic [47:0] m, logic [PW-1:0] p, bit good, bit pause);
    @(negedge clk);
    lrn_valid = 1; lrn_mac = m; lrn_port = p; lrn_good = good; lrn_pause = pause;
    @(posedge clk);
    if (good && !pause && !m[40]) begin
      m_v[slot(m)] = 1; m_mac[slot(m)] = m; m_port[slot(m)] = p; m_age[slot(m)] = 0;
    end
    @(negedge clk); lrn_valid = 0;
  endtask

  task automatic lookup(string req, logic [47:0] m);
    bit eh; logic [PW-1:0] ep;
    eh = !m[40] && m_v[slot(m)] && (m_mac[slot(m)] >> IW) == (m >> IW);
    ep = eh ? m_port[slot(m)] : '0;
    @(negedge clk); lkp_valid = 1; lkp_mac = m;
    @(posedge clk); #1;
    check({req, " valid"}, res_valid, 1);
    check({req, " hit"}, res_hit, eh);
    check({req, " port"}, res_port, ep);
    @(negedge clk); lkp_valid = 0;
  endtask

  task automatic tick();
    @(negedge clk); age_tick = 1;
    @(negedge clk); age_tick = 0;
    repeat (DEPTH + 6) @(negedge clk);
    if (cfg_age_en)
      for (int i = 0; i < DEPTH; i++)
        if (m_v[i]) begin
          if (m_age[i] >= cfg_age_limit) m_v[i] = 0; else m_age[i]++;
        end
  endtask

  function automatic logic [47:0] mk(int i);
    return {8'h02, 8'h11, 16'hC0DE, 4'(i), 4'(15 - i), 8'(i * 7)};
  endfunction

  initial begin
    logic [47:0] a, b, x;
    do_reset();
    // R1: reset state and empty table
    #1 check("R1 res_valid idle", res_valid, 0);
    for (int i = 0; i < DEPTH; i++) lookup("R1 empty", mk(i));

    // R2 R6 direct indexing, one address per slot
    for (int i = 0; i < DEPTH; i++) learn(mk(i), PW'(i ^ 5), 1, 0);
    for (int i = 0; i < DEPTH; i++) lookup("R2 R6 direct hit", mk(i));
    for (int i = 0; i < DEPTH; i++) lookup("R6 tag mismatch", mk(i) ^ 48'h1000_0000);

    // R4 ignored learns leave the resident entry intact
    x = mk(3) ^ 48'h0000_0100_0000;
    learn(x, 4'hA, 0, 0); lookup("R4 bad frame new", x); lookup("R4 bad frame old", mk(3));
    learn(x, 4'hA, 1, 1); lookup("R4 pause new", x);     lookup("R4 pause old", mk(3));
    x = mk(3) | 48'h0100_0000_0000;
    learn(x, 4'hA, 1, 0); lookup("R4 group SA", mk(3));
    // R3 group destination
    lookup("R3 group DA", x);
    // R6 eviction in direct mode, last learned wins
    x = mk(5) ^ 48'h10;
    learn(x, 4'h9, 1, 0); lookup("R6 evict old", mk(5)); lookup("R6 evict new", x);

    // R6 hash mode, exhaustive set with model-predicted collisions
    do_reset(); cfg_hash = 1;
    for (int i = 0; i < DEPTH; i++) learn(mk(i) ^ 48'(i << 12), PW'(i), 1, 0);
    for (int i = 0; i < DEPTH; i++) lookup("R6 hash", mk(i) ^ 48'(i << 12));
    a = 48'h0200_1234_5670;
    b = a ^ 48'h11;  // bit 4 folds onto index bit 0: same slot in hash mode
    learn(a, 4'h3, 1, 0); learn(b, 4'h4, 1, 0);
    lookup("R6 hash collide old", a); lookup("R6 hash collide new", b);

    // R7 lookup wins over a learn in the same cycle
    cfg_hash = 0; x = 48'h0200_7777_8880;
    @(negedge clk);
    lkp_valid = 1; lkp_mac = x; lrn_valid = 1; lrn_mac = x; lrn_port = 4'hC; lrn_good = 1; lrn_pause = 0;
    #1 check("R7 lrn_ready low", lrn_ready, 0);
    check("R7 lkp_ready high", lkp_ready, 1);
    @(posedge clk); #1;
    check("R7 lookup sees old table", res_hit, 0);
    @(negedge clk); lkp_valid = 0;
    #1 check("R7 lrn_ready high", lrn_ready, 1);
    @(posedge clk);
    m_v[slot(x)] = 1; m_mac[slot(x)] = x; m_port[slot(x)] = 4'hC; m_age[slot(x)] = 0;
    @(negedge clk); lrn_valid = 0;
    lookup("R7 learn then lookup", x);

    // R8 R5 aging with limit 2
    do_reset(); cfg_hash = 0; cfg_age_en = 1; cfg_age_limit = 3'd2;
    a = mk(1); b = mk(2);
    learn(a, 4'h1, 1, 0); learn(b, 4'h2, 1, 0);
    tick(); tick();
    lookup("R8 survives limit", a); lookup("R8 survives limit", b);
    learn(b, 4'h7, 1, 0);
    tick();
    lookup("R8 expired", a); lookup("R5 refreshed and moved", b);
    tick(); lookup("R5 still alive", b);
    tick(); lookup("R8 expired after refresh", b);

    // R9 aging disabled
    do_reset(); cfg_age_en = 0; cfg_age_limit = 3'd0;
    learn(a, 4'h6, 1, 0);
    repeat (3) tick();
    lookup("R9 ticks ignored", a);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule